// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital control front end for a multi-channel successive-approximation converter. It receives 16-bit command words from a serial-interface shim. The command words set the scan mode, the channel limit, a channel mask and an averaging setup. The block then walks the requested channels, asks an abstract converter for one conversion at a time, and writes tagged results into a result queue. The host drains that queue.

A mode-control write starts one pass of the selected scan if the sequencer is idle. A pass can be a single manual channel, an ascending sweep from channel 0 up to a limit, or a sweep over the channels set in a mask. Averaging takes several samples per channel and stores one mean per channel. The same mode-control word carries a two-bit reset field. That field either empties the result queue alone or restores all configuration and empties the queue.

Top module: `adc_scan_seq`

## Requirements
- R1: A command word with bit 15 = 0 is a mode-control write. Its fields are: bits 14:11 scan code, bits 10:7 channel number, bits 6:5 reset field. Scan code 0001 (manual), written while idle, converts only the named channel, once.
- R2: Scan code 0011, written while idle, converts channels 0 up to the named channel in ascending order, one conversion each. No channel is skipped, so both members of a differential pair are converted.
- R3: Scan code 0111, written while idle, converts in ascending order only the channels whose bit is 1 in a 16-bit mask. Command identifier bits 15:11 = 10100 loads mask bits 7:0 from word bits 7:0. Identifier 10101 loads mask bits 15:8 from word bits 7:0. An empty mask converts nothing.
- R4: Identifier 10000 loads the setup register: bits 1:0 select the average count N = 4 << value (4, 8, 16, 32), and bit 2 = 1 selects the external conversion clock. With scan code 1001 and the internal clock, each channel of an ascending sweep is converted N times. One result is stored per channel: the 17-bit sum shifted right by log2(N).
- R5: Scan code 1001 with the external clock selected falls back to one conversion per channel, and each raw sample is stored.
- R6: `conv_start` is a one-cycle pulse. No new request is issued until `conv_done` has been seen for the previous one. The next request follows one cycle after that `conv_done`.
- R7: The result queue holds 16 entries, first-word-fall-through. Each entry is {channel[3:0], data[11:0]}. A result that arrives while the queue is full, with no read in the same cycle, is dropped, and the sticky `fifo_overflow` is set.
- R8: Reset field 01 empties the result queue and clears `fifo_overflow`. The mask, the setup register and any running pass are left as they are.
- R9: Reset field 10 empties the queue, clears `fifo_overflow`, clears the mask and the setup register to 0, and stops any running pass. No pass starts from that word.
- R10: Identifier 11111 and every other unlisted identifier with bit 15 = 1 change nothing. Reset field 11 acts like 00.
- R11: Scan codes other than 0001, 0011, 0111 and 1001 start no conversion.
- R12: A mode-control write while a pass is running does not alter or restart the pass. Only its reset field takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command word |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 4 | Channel to convert, valid with `conv_start` |
| conv_done | input | 1 | Conversion finished pulse |
| conv_data | input | 12 | Conversion result, valid with `conv_done` |
| rd_en | input | 1 | Pop the head of the result queue |
| rd_data | output | 16 | Head entry {channel, data} |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_count | output | 5 | Number of entries held |
| fifo_overflow | output | 1 | Sticky: a result was dropped |

## Verification
The bench targets these corner cases:
- A full queue receives a 17th result. A wrong design would overwrite the head or wrap the count instead of dropping the result and flagging overflow.
- A reset field arrives in the middle of a pass. A wrong design would restart the pass from the new word, would fail to clear the mask and setup, or would accept the late `conv_done` from the aborted request.
- A sweep is averaged, and a sweep uses the external clock. Wrong sample counts or shifts show up as wrong stored means, and a wrong fallback shows up as extra requests.
- A reserved identifier carries a payload that would corrupt the mask if it were decoded loosely.
- An empty mask is given, and an unlisted scan code is given. Either one must issue no request at all.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and codes for the scan sequencer.
// Assumes: 16-bit command words; scan codes are fixed by the command format.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    localparam logic [3:0] SCAN_MANUAL = 4'b0001;
    localparam logic [3:0] SCAN_ASCEND = 4'b0011;
    localparam logic [3:0] SCAN_MASKED = 4'b0111;
    localparam logic [3:0] SCAN_AVERAGE = 4'b1001;

    localparam logic [1:0] RST_NONE  = 2'b00;
    localparam logic [1:0] RST_QUEUE = 2'b01;
    localparam logic [1:0] RST_ALL   = 2'b10;

    localparam logic [4:0] ID_SETUP   = 5'b10000;
    localparam logic [4:0] ID_MASK_LO = 5'b10100;
    localparam logic [4:0] ID_MASK_HI = 5'b10101;

endpackage

// File: rtl/cmd_decode.sv
// Module: cmd_decode
// Splits a 16-bit command word into write strobes and fields.
// Assumes: the word is valid only while cmd_valid is high. Identifiers that
// are not listed, the reserved all-ones one included, raise no strobe.
module cmd_decode (
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    output logic        mode_wr,
    output logic        setup_wr,
    output logic        mask_lo_wr,
    output logic        mask_hi_wr,
    output logic [3:0]  scan_code,
    output logic [3:0]  chan_sel,
    output logic [1:0]  rst_field,
    output logic [7:0]  payload
);
    import adc_seq_pkg::*;

    logic [4:0] reg_id;

    // Field extraction and identifier match.
    always_comb begin
        reg_id     = cmd_word[15:11];
        mode_wr    = cmd_valid && !cmd_word[15];
        setup_wr   = cmd_valid && (reg_id == ID_SETUP);
        mask_lo_wr = cmd_valid && (reg_id == ID_MASK_LO);
        mask_hi_wr = cmd_valid && (reg_id == ID_MASK_HI);
        scan_code  = cmd_word[14:11];
        chan_sel   = cmd_word[10:7];
        rst_field  = cmd_word[6:5];
        payload    = cmd_word[7:0];
    end

endmodule

// File: rtl/chan_pick.sv
// Module: chan_pick
// Finds the lowest set bit of a channel vector at or above a start index.
// Assumes: from may reach NUM_CH, which means no channel is left.
module chan_pick #(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] vec,
    input  logic [CH_W:0]     from,
    output logic              found,
    output logic [CH_W-1:0]   idx
);
    // Priority search from the top so that the lowest match wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (vec[i] && ((CH_W + 1)'(i) >= from)) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/result_fifo.sv
// Module: result_fifo
// First-word-fall-through result queue with a sticky overflow flag.
// Assumes: DEPTH is a power of two. clear takes priority over push and pop.
// A push when full is taken only if a pop happens in the same cycle.
module result_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic             pop_ok, push_ok, is_full;

    // Accept conditions for read and write.
    always_comb begin
        is_full = (count_q == CNT_W'(DEPTH));
        pop_ok  = pop && (count_q != '0);
        push_ok = push && (!is_full || pop_ok);
    end

    // Pointer, count and overflow update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
            if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
            else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
            if (push && !push_ok) ovf_q <= 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok && rst_n && !clear) mem_q[wr_ptr_q] <= push_data;
    end

    assign rd_data  = mem_q[rd_ptr_q];
    assign empty    = (count_q == '0);
    assign count    = count_q;
    assign overflow = ovf_q;

    // R7: the count never exceeds the depth.
    always_comb begin
        if (rst_n) assert_count_bound_R7: assert (count_q <= CNT_W'(DEPTH));
    end

    // R7: a push into a full queue without a pop keeps it full and flags overflow.
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push && !pop && !clear) |=> (count_q == CNT_W'(DEPTH) && ovf_q));

    // R8: a clear leaves the queue empty with the flag low.
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0 && !ovf_q));

endmodule

// File: rtl/adc_scan_seq.sv
// Module: adc_scan_seq (top)
// Decodes commands, runs manual, ascending, masked and averaged passes over
// the channels, issues one conversion at a time and queues tagged results.
// Assumes: the converter answers each conv_start with one conv_done. A
// conv_done seen while idle is ignored.
module adc_scan_seq #(
    parameter int NUM_CH     = 16,
    parameter int DATA_W     = 12,
    parameter int FIFO_DEPTH = 16,
    parameter int AVG_SEL_W  = 2,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int ENTRY_W   = CH_W + DATA_W,
    localparam int MAX_AVG   = 4 << ((1 << AVG_SEL_W) - 1),
    localparam int ACC_W     = DATA_W + $clog2(MAX_AVG),
    localparam int SMP_W     = $clog2(MAX_AVG) + 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [15:0]        cmd_word,
    output logic               conv_start,
    output logic [CH_W-1:0]    conv_chan,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  conv_data,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               fifo_empty,
    output logic [CNT_W-1:0]   fifo_count,
    output logic               fifo_overflow
);
    import adc_seq_pkg::*;

    logic                 mode_wr, setup_wr, mask_lo_wr, mask_hi_wr;
    logic [3:0]           scan_code, chan_sel;
    logic [1:0]           rst_field;
    logic [7:0]           payload;

    seq_state_t           state_q;
    logic [NUM_CH-1:0]    mask_q, scan_vec_q, start_vec;
    logic [AVG_SEL_W-1:0] avg_sel_q, run_sel_q;
    logic                 ext_clk_q, avg_en_q;
    logic [CH_W-1:0]      cur_ch_q;
    logic [SMP_W-1:0]     samp_q, n_target;
    logic [ACC_W-1:0]     acc_q, sum;
    logic [SMP_W-1:0]     shift_amt;
    logic                 first_found, nxt_found, last_samp, push, do_wipe, q_clear;
    logic [CH_W-1:0]      first_idx, nxt_idx;
    logic [DATA_W-1:0]    mean;

    cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .mode_wr   (mode_wr),
        .setup_wr  (setup_wr),
        .mask_lo_wr(mask_lo_wr),
        .mask_hi_wr(mask_hi_wr),
        .scan_code (scan_code),
        .chan_sel  (chan_sel),
        .rst_field (rst_field),
        .payload   (payload)
    );

    // Channel set that a mode write would run, from the new word and the mask.
    always_comb begin
        start_vec = '0;
        case (scan_code)
            SCAN_MANUAL: start_vec[chan_sel] = 1'b1;
            SCAN_ASCEND, SCAN_AVERAGE: begin
                for (int i = 0; i < NUM_CH; i++) start_vec[i] = (CH_W'(i) <= chan_sel);
            end
            SCAN_MASKED: start_vec = mask_q;
            default:     start_vec = '0;
        endcase
    end

    chan_pick #(.NUM_CH(NUM_CH)) u_pick_first (
        .vec  (start_vec),
        .from ('0),
        .found(first_found),
        .idx  (first_idx)
    );

    chan_pick #(.NUM_CH(NUM_CH)) u_pick_next (
        .vec  (scan_vec_q),
        .from ({1'b0, cur_ch_q} + 1'b1),
        .found(nxt_found),
        .idx  (nxt_idx)
    );

    // Sample target, running sum and the mean written on the last sample.
    always_comb begin
        n_target  = avg_en_q ? (SMP_W'(4) << run_sel_q) : SMP_W'(1);
        shift_amt = avg_en_q ? (SMP_W'(2) + SMP_W'(run_sel_q)) : '0;
        last_samp = (samp_q == n_target - 1'b1);
        sum       = acc_q + ACC_W'(conv_data);
        mean      = DATA_W'(sum >> shift_amt);
        push      = (state_q == ST_WAIT) && conv_done && last_samp;
        do_wipe   = mode_wr && (rst_field == RST_ALL);
        q_clear   = mode_wr && ((rst_field == RST_QUEUE) || (rst_field == RST_ALL));
    end

    // Configuration registers: mask and averaging setup.
    always_ff @(posedge clk) begin
        if (!rst_n || do_wipe) begin
            mask_q    <= '0;
            avg_sel_q <= '0;
            ext_clk_q <= 1'b0;
        end else begin
            if (mask_lo_wr) mask_q[7:0]  <= payload;
            if (mask_hi_wr) mask_q[15:8] <= payload;
            if (setup_wr) begin
                avg_sel_q <= payload[AVG_SEL_W-1:0];
                ext_clk_q <= payload[AVG_SEL_W];
            end
        end
    end

    // Pass control: start, request, wait, accumulate and advance.
    always_ff @(posedge clk) begin
        if (!rst_n || do_wipe) begin
            state_q    <= ST_IDLE;
            scan_vec_q <= '0;
            cur_ch_q   <= '0;
            avg_en_q   <= 1'b0;
            run_sel_q  <= '0;
            samp_q     <= '0;
            acc_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (mode_wr && first_found) begin
                        scan_vec_q <= start_vec;
                        cur_ch_q   <= first_idx;
                        avg_en_q   <= (scan_code == SCAN_AVERAGE) && !ext_clk_q;
                        run_sel_q  <= avg_sel_q;
                        samp_q     <= '0;
                        acc_q      <= '0;
                        state_q    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_done) begin
                        if (last_samp) begin
                            samp_q <= '0;
                            acc_q  <= '0;
                            if (nxt_found) begin
                                cur_ch_q <= nxt_idx;
                                state_q  <= ST_ISSUE;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            samp_q  <= samp_q + 1'b1;
                            acc_q   <= sum;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign conv_start = (state_q == ST_ISSUE);
    assign conv_chan  = cur_ch_q;

    result_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (q_clear),
        .push     (push),
        .push_data({cur_ch_q, mean}),
        .pop      (rd_en),
        .rd_data  (rd_data),
        .empty    (fifo_empty),
        .count    (fifo_count),
        .overflow (fifo_overflow)
    );

    // R6: a request is never followed directly by another request.
    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R3: every requested channel belongs to the set latched for the pass.
    assert_chan_in_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> scan_vec_q[conv_chan]);

    // R4: the sample counter stays below the target while waiting.
    assert_avg_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (samp_q < n_target));

    // R10: a reserved identifier leaves the mask and the setup unchanged.
    assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[15:11] == 5'b11111) |=> ($stable(mask_q) && $stable(avg_sel_q) && $stable(ext_clk_q)));

    // R12: a mode write during a pass without full reset keeps the pass running.
    assert_busy_keeps_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && mode_wr && rst_field != RST_ALL) |=> (state_q != ST_IDLE && $stable(scan_vec_q)));

endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the design on every clock.
module adc_scan_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        rd_en = 1'b0;
    logic        conv_start, fifo_empty, fifo_overflow;
    logic [3:0]  conv_chan;
    logic [15:0] rd_data;
    logic [4:0]  fifo_count;

    adc_scan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .fifo_count(fifo_count), .fifo_overflow(fifo_overflow)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    nconv  = 0;
    int    pend   = 0;
    int    resp_ch = 0;
    bit    live = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    int  m_list[$];
    int  m_fifo[$];
    bit  m_busy, m_issue, m_ovf, m_ext;
    int  m_n, m_k, m_acc, m_shift, m_sel;
    int  m_mask;

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Model update at each edge from the bench-driven inputs.
    always @(posedge clk) begin
        bit was_busy, nxt_issue, do_push;
        int pv, id, code, ch, rs;
        cycles++;
        if (!rst_n) begin
            m_list.delete(); m_fifo.delete();
            m_busy = 0; m_issue = 0; m_ovf = 0; m_ext = 0;
            m_n = 1; m_k = 0; m_acc = 0; m_shift = 0; m_sel = 0; m_mask = 0;
        end else begin
            was_busy = m_busy; nxt_issue = 0; do_push = 0; pv = 0;
            if (m_busy && !m_issue && conv_done) begin
                m_acc += int'(conv_data); m_k++;
                if (m_k == m_n) begin
                    pv = (m_list[0] << 12) | ((m_acc >> m_shift) & 'hfff);
                    do_push = 1; m_k = 0; m_acc = 0;
                    void'(m_list.pop_front());
                    if (m_list.size() == 0) m_busy = 0; else nxt_issue = 1;
                end else nxt_issue = 1;
            end
            m_issue = nxt_issue;
            if (rd_en && m_fifo.size() > 0) void'(m_fifo.pop_front());
            if (do_push) begin
                if (m_fifo.size() < 16) m_fifo.push_back(pv); else m_ovf = 1;
            end
            if (cmd_valid) begin
                id = int'(cmd_word[15:11]);
                if (!cmd_word[15]) begin
                    code = int'(cmd_word[14:11]); ch = int'(cmd_word[10:7]); rs = int'(cmd_word[6:5]);
                    if (rs == 2) begin
                        m_fifo.delete(); m_ovf = 0; m_busy = 0; m_issue = 0; m_list.delete();
                        m_mask = 0; m_sel = 0; m_ext = 0;
                    end else begin
                        if (rs == 1) begin m_fifo.delete(); m_ovf = 0; end
                        if (!was_busy) begin
                            m_list.delete();
                            if (code == 1) m_list.push_back(ch);
                            else if (code == 3 || code == 9) for (int i = 0; i <= ch; i++) m_list.push_back(i);
                            else if (code == 7) for (int i = 0; i < 16; i++) if (m_mask[i]) m_list.push_back(i);
                            if (code == 9 && !m_ext) begin m_n = 4 << m_sel; m_shift = 2 + m_sel; end
                            else begin m_n = 1; m_shift = 0; end
                            m_k = 0; m_acc = 0;
                            if (m_list.size() > 0) begin m_busy = 1; m_issue = 1; end
                        end
                    end
                end else if (id == 5'b10000) begin
                    m_sel = int'(cmd_word[1:0]); m_ext = cmd_word[2];
                end else if (id == 5'b10100) begin
                    m_mask = (m_mask & 'hff00) | int'(cmd_word[7:0]);
                end else if (id == 5'b10101) begin
                    m_mask = (m_mask & 'h00ff) | (int'(cmd_word[7:0]) << 8);
                end
            end
        end
    end

    // Per-clock comparison of outputs against the model.
    always @(negedge clk) begin
        if (live) begin
            check(conv_start == m_issue, "R6", conv_start, m_issue, "conv_start");
            if (conv_start && m_list.size() > 0)
                check(int'(conv_chan) == m_list[0], cur_req, conv_chan, m_list[0], "conv_chan");
            check(int'(fifo_count) == m_fifo.size(), "R7", fifo_count, m_fifo.size(), "fifo_count");
            check(fifo_overflow == m_ovf, "R7", fifo_overflow, m_ovf, "overflow");
            check(fifo_empty == (m_fifo.size() == 0), "R7", fifo_empty, m_fifo.size() == 0, "empty");
            if (m_fifo.size() > 0)
                check(int'(rd_data) == m_fifo[0], cur_req, rd_data, m_fifo[0], "rd_data");
        end
    end

    // Converter responder: answers each request after 1 to 3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    conv_done = 1'b1;
                    conv_data = 12'((resp_ch * 273 + nconv * 97 + 5) & 'hfff);
                end
            end else if (conv_start) begin
                resp_ch = int'(conv_chan);
                nconv++;
                pend = 1 + (nconv % 3);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
    end

    function automatic logic [15:0] mode_w(input int code, input int ch, input int rs);
        return {1'b0, 4'(code), 4'(ch), 2'(rs), 5'b0};
    endfunction

    task automatic send(input logic [15:0] w);
        @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
        @(negedge clk); cmd_valid = 1'b0; cmd_word = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!m_busy && pend == 0 && !conv_done) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic drain();
        while (m_fifo.size() > 0) begin
            @(negedge clk); rd_en = 1'b1;
            @(negedge clk); rd_en = 1'b0;
        end
    endtask

    task automatic run_count(input logic [15:0] w, input string req, input int exp);
        int base;
        base = nconv;
        send(w);
        wait_idle();
        check(nconv - base == exp, req, nconv - base, exp, "conversion count");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fifo_empty && fifo_count == 0 && !conv_start && !fifo_overflow, "R7", fifo_count, 0, "reset state");
        live = 1'b1;

        cur_req = "R1"; run_count(mode_w(1, 5, 0), "R1", 1);
        check(rd_data[15:12] == 4'd5, "R1", rd_data[15:12], 5, "manual tag");
        drain();

        cur_req = "R2"; run_count(mode_w(3, 6, 0), "R2", 7); drain();

        cur_req = "R3";
        send({5'b10100, 3'b0, 8'h55}); send({5'b10101, 3'b0, 8'h55});
        run_count(mode_w(7, 0, 0), "R3", 8); drain();

        cur_req = "R4";
        send({5'b10000, 8'b0, 3'b001});
        run_count(mode_w(9, 2, 0), "R4", 24);
        check(fifo_count == 3, "R4", fifo_count, 3, "one mean per channel");
        drain();

        cur_req = "R5";
        send({5'b10000, 8'b0, 3'b101});
        run_count(mode_w(9, 3, 0), "R5", 4); drain();
        send({5'b10000, 8'b0, 3'b000});

        cur_req = "R11"; run_count(mode_w(4'b0101, 4, 0), "R11", 0);
        run_count(mode_w(4'b1111, 2, 0), "R11", 0);

        cur_req = "R10";
        send(16'hF8F0); send({5'b10110, 3'b0, 8'hFF});
        run_count(mode_w(7, 0, 3), "R10", 8);
        check(fifo_count == 8, "R10", fifo_count, 8, "reset 11 kept queue");
        drain();

        cur_req = "R12";
        send(mode_w(3, 9, 0));
        repeat (8) @(negedge clk);
        send(mode_w(1, 1, 1));
        wait_idle();
        check(m_fifo.size() < 10 && int'(fifo_count) == m_fifo.size(), "R12", fifo_count, m_fifo.size(), "pass continued after clear");
        drain();

        cur_req = "R7";
        run_count(mode_w(3, 15, 0), "R7", 16);
        check(fifo_count == 16 && !fifo_overflow, "R7", fifo_count, 16, "queue full");
        run_count(mode_w(1, 2, 0), "R7", 1);
        check(fifo_overflow && fifo_count == 16 && rd_data[15:12] == 4'd0, "R7", fifo_overflow, 1, "drop on full");

        cur_req = "R8";
        send(mode_w(0, 0, 1));
        @(negedge clk);
        check(fifo_count == 0 && !fifo_overflow, "R8", fifo_count, 0, "queue reset");
        run_count(mode_w(7, 0, 0), "R8", 8);
        drain();

        cur_req = "R9";
        send({5'b10100, 3'b0, 8'hFF}); send({5'b10000, 8'b0, 3'b011});
        send(mode_w(3, 7, 0));
        repeat (6) @(negedge clk);
        send(mode_w(3, 5, 2));
        wait_idle();
        check(fifo_count == 0 && !fifo_overflow, "R9", fifo_count, 0, "full reset aborts");
        run_count(mode_w(7, 0, 0), "R9", 0);
        run_count(mode_w(9, 0, 0), "R9", 4);
        drain();

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule